// File: doc/BRIEF.md
# Frame Capture Write Engine

This block copies one frame of pixels from a display stream into memory. Software sets a destination base address, a line pitch and the frame dimensions through a small 32-bit register port. It then writes the control register with the start bit set. The block takes packed 32-bit pixel words from the stream. Each accepted word becomes one word write request carrying an address, the data and byte strobes. Addresses run upward in 4-byte steps along a line. When a word marked as line end is taken, the next line begins at the previous line start plus the pitch.

A busy flag is set while a frame is in flight. It clears when the word marked as frame end has been accepted by memory, or at once when software writes the abort bit. When the block goes idle with the interrupt enable set, it raises a level interrupt. That interrupt stays high until software writes the control register back with the enable cleared. A progress register counts lines whose last word memory has accepted. A vertical-start pulse marks each frame start, and a debug option repeats it at frame end.

Top module: `fwb_capture`

## Requirements
- R1: After reset the block is idle: busy, interrupt, vertical-start, write-request valid and stream ready are all 0. The pointer, pitch, dimension and progress registers read 0.
- R2: Registers are selected by word index: 0 pointer, 1 pitch, 2 dimensions (height in bits 31:16, width in bits 15:0), 3 control, 4 progress. Pointer bits 1:0 and pitch bits 3:0 are dropped on write and read back as 0. The dimensions register reads back exactly as written. Read data appears one cycle after the index is presented.
- R3: Control bits 31:24 always read 0x54 and bits 23:22 read 01. Bit 0 reads 0 and bit 1 reads busy. Bits 21:15 and 13:2 read back as last written while idle. Bit 14 reads 0.
- R4: Writing control while idle with bit 0 set and bit 21 clear starts a frame. Busy is 1 and vertical-start pulses for one cycle, both visible the cycle after the write. Writing bit 0 while busy does not restart the frame: progress and addresses carry on.
- R5: The first word of a frame is written at the pointer. Each later word in a line is 4 bytes above the one before it. The word after a line end is written at the previous line start plus the pitch.
- R6: Each write request carries the accepted pixel word unchanged, with strobes equal to control bits 19:16.
- R7: Progress is cleared at frame start and counts up by one when memory accepts the last word of a line. A word with the frame-end marker also ends a line.
- R8: Busy is 0 the cycle after memory accepts the frame-end word. After the frame-end word has been taken, the stream is not accepted again.
- R9: When control bit 2 is set and the block goes idle, the interrupt output rises and stays high. Writing control with bit 2 clear drops it in the next cycle.
- R10: Writing control bit 14 while busy ends the frame. The next cycle, busy and write-request valid are 0 and the stream is not accepted. Any word held for memory is dropped.
- R11: A control write with bit 21 set does not start a frame, even with bit 0 set. The block stays idle and does not accept the stream.
- R12: When control bit 15 is set, vertical-start also pulses the cycle after the frame-end word is accepted. When bit 15 is clear, it does not.
- R13: While busy, a control write changes no stored control field and cannot clear the interrupt enable. Only the abort bit has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the index |
| pix_valid | input | 1 | Stream word valid |
| pix_ready | output | 1 | Stream word accepted when high with valid |
| pix_data | input | 32 | Packed pixel word |
| pix_eol | input | 1 | Word is the last of its line |
| pix_eof | input | 1 | Word is the last of the frame |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the request |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Word to store |
| wr_strb | output | 4 | Byte strobes |
| irq | output | 1 | Level interrupt on idle |
| vstart | output | 1 | Vertical-start pulse |

## Verification
Several frames are captured with memory back-pressure drawn at random. This catches an output stage that loses or repeats a word when memory stalls at a line end; such a design writes the next line at a wrong address, or counts a line twice. Start bits written in the middle of a frame, with other control bits changed, expose a design that restarts or alters its strobes or interrupt enable while busy. An abort issued while a word is stalled towards memory catches a design that still lets that word out. A start written together with the power-down bit must leave the block idle, and a design that ignores power-down would raise busy. Interrupt clear, frame-end vertical-start and the progress count, both mid-frame and at frame end, are checked in the cycle the requirements name, so a one-cycle slip in any of them is reported.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // register word indices
  localparam logic [2:0] IDX_PTR   = 3'd0;
  localparam logic [2:0] IDX_PITCH = 3'd1;
  localparam logic [2:0] IDX_DIM   = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd3;
  localparam logic [2:0] IDX_PROG  = 3'd4;

  // control bit positions
  localparam int B_GO    = 0;
  localparam int B_BUSY  = 1;
  localparam int B_IRQEN = 2;
  localparam int B_ABORT = 14;
  localparam int B_VSEOF = 15;
  localparam int B_STRB  = 16;
  localparam int B_PWRDN = 21;

  // fixed identification bits and the mask of stored control bits
  localparam logic [31:0] CTRL_ID    = 32'h5440_0000;
  localparam logic [31:0] CTRL_STORE = 32'h003F_BFFC;
endpackage

// File: rtl/fwb_regs.sv
module fwb_regs
  import fwb_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic [LINE_W-1:0] progress,
  output logic [31:0]       ptr_q,
  output logic [31:0]       pitch_q,
  output logic              irq_en,
  output logic              vs_eof,
  output logic [3:0]        strb_cfg,
  output logic              go_req,
  output logic              abort_req
);
  logic [31:0] dim_q;
  logic [31:0] ctrl_q;
  logic        ctrl_hit;

  assign ctrl_hit  = cfg_wr && (cfg_addr == IDX_CTRL);
  assign go_req    = ctrl_hit && !busy && cfg_wdata[B_GO] && !cfg_wdata[B_PWRDN];
  assign abort_req = ctrl_hit && busy && cfg_wdata[B_ABORT];

  assign irq_en   = ctrl_q[B_IRQEN];
  assign vs_eof   = ctrl_q[B_VSEOF];
  assign strb_cfg = ctrl_q[B_STRB +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      pitch_q <= '0;
      dim_q   <= '0;
      ctrl_q  <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        IDX_PTR:   ptr_q   <= {cfg_wdata[31:2], 2'b00};
        IDX_PITCH: pitch_q <= {cfg_wdata[31:4], 4'b0000};
        IDX_DIM:   dim_q   <= cfg_wdata;
        IDX_CTRL:  if (!busy) ctrl_q <= cfg_wdata & CTRL_STORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        IDX_PTR:   cfg_rdata <= ptr_q;
        IDX_PITCH: cfg_rdata <= pitch_q;
        IDX_DIM:   cfg_rdata <= dim_q;
        IDX_CTRL:  cfg_rdata <= ctrl_q | CTRL_ID | (32'(busy) << B_BUSY);
        IDX_PROG:  cfg_rdata <= 32'(progress);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  // R11
  pwrdn_no_go_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && cfg_wdata[B_PWRDN]) |-> !go_req);
endmodule

// File: rtl/fwb_engine.sv
module fwb_engine #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  input  logic [31:0]       ptr,
  input  logic [31:0]       pitch,
  input  logic              irq_en,
  input  logic              vs_eof,
  input  logic [3:0]        strb_cfg,
  input  logic              pix_valid,
  input  logic [31:0]       pix_data,
  input  logic              pix_eol,
  input  logic              pix_eof,
  output logic              pix_ready,
  output logic              wr_valid,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  input  logic              wr_ready,
  output logic              busy,
  output logic              irq,
  output logic              vstart,
  output logic [LINE_W-1:0] progress
);
  logic [31:0] line_q, word_q, next_line;
  logic        out_eol_q, out_eof_q, done_q;
  logic        out_fire, pix_fire;

  assign next_line = line_q + pitch;
  assign out_fire  = wr_valid && wr_ready;
  assign pix_ready = busy && !(wr_valid && out_eof_q) && (!wr_valid || wr_ready);
  assign pix_fire  = pix_valid && pix_ready;
  assign irq       = done_q && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_q    <= 1'b0;
      vstart    <= 1'b0;
      progress  <= '0;
      line_q    <= '0;
      word_q    <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_strb   <= '0;
      out_eol_q <= 1'b0;
      out_eof_q <= 1'b0;
    end else begin
      vstart <= 1'b0;
      if (go) begin
        busy      <= 1'b1;
        done_q    <= 1'b0;
        progress  <= '0;
        line_q    <= ptr;
        word_q    <= ptr;
        wr_valid  <= 1'b0;
        out_eol_q <= 1'b0;
        out_eof_q <= 1'b0;
        vstart    <= 1'b1;
      end else if (abort) begin
        busy     <= 1'b0;
        done_q   <= 1'b1;
        wr_valid <= 1'b0;
      end else if (busy) begin
        if (out_fire) begin
          wr_valid <= 1'b0;
          if (out_eol_q || out_eof_q) progress <= progress + 1'b1;
          if (out_eof_q) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
            vstart <= vs_eof;
          end
        end
        if (pix_fire) begin
          wr_valid  <= 1'b1;
          wr_addr   <= word_q;
          wr_data   <= pix_data;
          wr_strb   <= strb_cfg;
          out_eol_q <= pix_eol;
          out_eof_q <= pix_eof;
          if (pix_eol || pix_eof) begin
            line_q <= next_line;
            word_q <= next_line;
          end else begin
            word_q <= word_q + 32'd4;
          end
        end
      end
    end
  end

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_valid);
  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);
  // R7
  prog_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (progress == '0));
  // R4
  start_vs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> vstart);
  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !wr_valid));
  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[1:0] == 2'b00));
endmodule

// File: rtl/fwb_capture.sv
module fwb_capture #(
  parameter int LINE_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pix_valid,
  output logic        pix_ready,
  input  logic [31:0] pix_data,
  input  logic        pix_eol,
  input  logic        pix_eof,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_strb,
  output logic        irq,
  output logic        vstart
);
  logic [31:0]       ptr_q, pitch_q;
  logic              irq_en, vs_eof, go_req, abort_req, busy;
  logic [3:0]        strb_cfg;
  logic [LINE_W-1:0] progress;

  fwb_regs #(.LINE_W(LINE_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .progress(progress), .ptr_q(ptr_q), .pitch_q(pitch_q),
    .irq_en(irq_en), .vs_eof(vs_eof), .strb_cfg(strb_cfg),
    .go_req(go_req), .abort_req(abort_req)
  );

  fwb_engine #(.LINE_W(LINE_W)) u_engine (
    .clk(clk), .rst(rst), .go(go_req), .abort(abort_req),
    .ptr(ptr_q), .pitch(pitch_q), .irq_en(irq_en), .vs_eof(vs_eof),
    .strb_cfg(strb_cfg), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .pix_ready(pix_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .wr_ready(wr_ready), .busy(busy), .irq(irq),
    .vstart(vstart), .progress(progress)
  );
endmodule

// File: tb/test_fwb_capture.sv
module test_fwb_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pix_valid = 1'b0, pix_eol = 1'b0, pix_eof = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_ready;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_strb;
  logic        irq, vstart;

  int checks = 0, fails = 0;
  int cur_w, cur_l;
  logic [31:0] cur_ptr, cur_pitch, cur_ctrl;
  logic [3:0]  cur_strb;
  logic [31:0] rd;

  always #10 clk = ~clk;

  fwb_capture i_fwb_capture (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_eol(pix_eol),
    .pix_eof(pix_eof), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .irq(irq), .vstart(vstart)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(posedge clk); @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] exp_addr(input int k);
    return cur_ptr + 32'(k / cur_w) * cur_pitch + 32'(k % cur_w) * 32'd4;
  endfunction

  // run the stream from word first to word stop-1 with random back-pressure
  task automatic run_words(input int first, input int stop);
    int idx = first, oidx = first, total = cur_w * cur_l;
    while (oidx < stop) begin
      wr_ready  = ($urandom % 4) != 0;
      pix_valid = (idx < stop) && (($urandom % 5) != 0);
      pix_data  = pat(idx);
      pix_eol   = (idx % cur_w) == cur_w - 1;
      pix_eof   = idx == total - 1;
      #1;
      if (wr_valid && wr_ready) begin
        chk("R5 addr", wr_addr, exp_addr(oidx));
        chk("R6 data", wr_data, pat(oidx));
        chk("R6 strb", 32'(wr_strb), 32'(cur_strb));
        oidx++;
      end
      if (pix_valid && pix_ready) idx++;
      @(posedge clk); @(negedge clk);
    end
    pix_valid = 1'b0; wr_ready = 1'b0;
  endtask

  task automatic start(input int w, input int l, input logic [31:0] p,
                       input logic [31:0] pit, input logic [31:0] ctrl);
    cur_w = w; cur_l = l;
    cur_ptr = p & ~32'h3; cur_pitch = pit & ~32'hF;
    cur_strb = ctrl[19:16]; cur_ctrl = ctrl;
    reg_wr(3'd0, p);
    reg_wr(3'd1, pit);
    reg_wr(3'd2, {16'(l), 16'(w)});
    reg_wr(3'd3, ctrl);
    chk("R4 busy after start", 32'(i_fwb_capture.wr_valid === 1'b0 && pix_ready), 32'd1);
    chk("R4 vstart pulse", 32'(vstart), 32'd1);
  endtask

  task automatic end_checks(input logic ie, input logic vse);
    chk("R8 idle after eof", 32'(pix_ready), 32'd0);
    chk("R9 irq on idle", 32'(irq), 32'(ie));
    chk("R12 vstart at eof", 32'(vstart), 32'(vse));
    reg_rd(3'd3, rd);
    chk("R8 busy bit clear", 32'(rd[1]), 32'd0);
    reg_rd(3'd4, rd);
    chk("R7 progress at end", rd, 32'(cur_l));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vstart", 32'(vstart), 0);
    chk("R1 wr_valid", 32'(wr_valid), 0);
    chk("R1 pix_ready", 32'(pix_ready), 0);
    reg_rd(3'd0, rd); chk("R1 ptr", rd, 0);
    reg_rd(3'd4, rd); chk("R1 progress", rd, 0);
    reg_rd(3'd3, rd); chk("R3 ctrl id at reset", rd, 32'h5440_0000);

    // R2 register masking and readback
    reg_wr(3'd0, 32'h1234_5677); reg_rd(3'd0, rd); chk("R2 ptr low bits", rd, 32'h1234_5674);
    reg_wr(3'd1, 32'h0000_0123); reg_rd(3'd1, rd); chk("R2 pitch low bits", rd, 32'h0000_0120);
    reg_wr(3'd2, 32'h0438_0780); reg_rd(3'd2, rd); chk("R2 dim", rd, 32'h0438_0780);

    // frame A: irq enabled, full strobes
    c = 32'h000F_0005;
    start(5, 3, 32'h8000_1003, 32'h0000_0030, c);
    reg_rd(3'd3, rd); chk("R3 ctrl while busy", rd, (c & 32'h003F_BFFC) | 32'h5440_0002);
    run_words(0, 15);
    end_checks(1'b1, 1'b0);
    reg_wr(3'd3, 32'h000F_0000);
    chk("R9 irq cleared", 32'(irq), 0);

    // frame B: vstart at eof, mid-frame restart attempt
    c = 32'h0005_8001;
    start(4, 4, 32'h0040_0200, 32'h0000_0040, c);
    run_words(0, 6);
    reg_rd(3'd4, rd); chk("R7 progress mid frame", rd, 1);
    reg_wr(3'd3, 32'h000A_0005);
    reg_rd(3'd3, rd); chk("R13 ctrl unchanged while busy", rd, (c & 32'h003F_BFFC) | 32'h5440_0002);
    reg_rd(3'd4, rd); chk("R4 no restart on busy go", rd, 1);
    run_words(6, 16);
    end_checks(1'b0, 1'b1);

    // R10 abort with a word stalled toward memory
    c = 32'h000F_0005;
    start(8, 4, 32'h0100_0000, 32'h0000_0040, c);
    run_words(0, 3);
    pix_valid = 1'b1; pix_data = pat(3); pix_eol = 1'b0; pix_eof = 1'b0; wr_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 word stalled", 32'(wr_valid), 1);
    reg_wr(3'd3, 32'h0000_4000);
    chk("R10 wr_valid dropped", 32'(wr_valid), 0);
    chk("R10 stream refused", 32'(pix_ready), 0);
    chk("R10 irq after abort", 32'(irq), 1);
    wr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 no later write", 32'(wr_valid), 0);
    pix_valid = 1'b0; wr_ready = 1'b0;
    reg_rd(3'd3, rd); chk("R10 busy clear", 32'(rd[1]), 0);
    reg_wr(3'd3, 32'h0);

    // R11 power-down with start
    reg_wr(3'd3, 32'h0020_0001);
    pix_valid = 1'b1;
    #1;
    chk("R11 no vstart", 32'(vstart), 0);
    chk("R11 stream refused", 32'(pix_ready), 0);
    pix_valid = 1'b0;
    reg_rd(3'd3, rd); chk("R11 ctrl readback", rd, 32'h5460_0000);

    // random frames
    for (int f = 0; f < 4; f++) begin
      int w = 1 + int'($urandom % 6);
      int l = 1 + int'($urandom % 4);
      logic [31:0] pit = 32'(((w * 4 + 15) / 16) * 16 + 16 * int'($urandom % 3)) | ($urandom & 32'hF);
      logic ie = $urandom % 2;
      logic vse = $urandom % 2;
      logic [3:0] sb = 4'($urandom);
      c = {12'h0, sb, vse, 12'h0, ie, 2'b01};
      start(w, l, $urandom, pit, c);
      run_words(0, w * l);
      end_checks(ie, vse);
      reg_wr(3'd3, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule